// File: doc/BRIEF.md
# Register-Controlled Multiply-Accumulate Unit

This block sits on a simple synchronous register bus and computes 16x16 products, signed or unsigned. It can store the product as a new 32-bit result or add it into the result already held. Software never selects the operation directly. The bus address that receives the first operand chooses both the signedness and whether the result is overwritten or accumulated. Writing the second operand launches one computation with that choice. The chosen operation is internal state, and reading any first-operand address only returns the operand value.

The 32-bit result is split into a low and a high data word. A third word holds extension information: the carry out of an unsigned accumulation, or the sign of a signed result. Software may load the two result words directly to give an accumulation a starting value. Each computation lands in the result words a fixed three clock cycles after its start write. Until then, reads return the previous result. A `busy` output stays high while any computation is still in flight. Back-to-back start writes are pipelined, and each one lands in its own cycle.

Top module: `mac_periph`

## Requirements
- R1: A synchronous active-low reset sets the first operand, second operand, both result words and the extension word to zero. It drops `busy` and selects plain unsigned multiply, so a start after reset replaces a preloaded result instead of adding to it.
- R2: The first operand can be written at byte address 0x130, 0x132, 0x134 or 0x136. These select plain unsigned multiply, plain signed multiply, unsigned accumulate and signed accumulate respectively, and the most recent such write fixes the operation for later starts.
- R3: A read of any of the four first-operand addresses returns the last first-operand value written, whichever address was used. A read of 0x138 returns the last second operand.
- R4: Each write to 0x138 starts one computation. Its result appears at 0x13A (low half) and 0x13C (high half) on the third rising edge after the start write. Reads in the two cycles before that edge return the previous result.
- R5: `busy` is high in every cycle after a start write up to and including the cycle before its result lands, and low once no computation is in flight.
- R6: In plain unsigned multiply the result is the 32-bit unsigned product and the extension word (0x13E) reads 0x0000.
- R7: In plain signed multiply the result is the two's-complement product and the extension word reads 0xFFFF if the product is negative, else 0x0000.
- R8: In unsigned accumulate the result becomes the old 32-bit result plus the unsigned product, modulo 2^32, and the extension word reads the carry out of that addition (0x0000 or 0x0001).
- R9: In signed accumulate the result becomes the old result plus the signed product, modulo 2^32, and the extension word reads 0xFFFF if bit 31 of the new result is set, else 0x0000.
- R10: Writes to 0x13A and 0x13C load the low and high result words and read back. Writes to 0x13E are ignored and leave the extension word unchanged.
- R11: Start writes on consecutive cycles each produce a result three edges after their own start, and each accumulation adds onto the result left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Byte address of the access. Only even addresses in the 16-byte window at BASE decode. |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| busy | output | 1 | High while a started computation has not yet landed |

## Verification
The hardest situation to reach is two accumulating starts in consecutive cycles. Here the second addition must use the result that the first one writes on the edge just before. The bench writes the first operand once and then issues two second-operand writes on adjacent edges. The scoreboard queues two expected results with their own due cycles and checks that each one is read exactly on its landing cycle. Carry and sign corner cases come from preloading the result words to 0xFFFFFFFF or zero before an accumulation, so the extension word must flip.

// File: rtl/mac_pkg.sv
// Package: shared encodings for the multiply-accumulate unit.
// The operation code equals the word index of the first-operand address
// it is written through: bit 0 = signed, bit 1 = accumulate.
package mac_pkg;

    typedef enum logic [1:0] {
        OP_UMUL = 2'd0,
        OP_SMUL = 2'd1,
        OP_UACC = 2'd2,
        OP_SACC = 2'd3
    } mac_op_e;

    // word index inside the 16-byte register window
    localparam logic [2:0] WIDX_OPB   = 3'd4;
    localparam logic [2:0] WIDX_RLO   = 3'd5;
    localparam logic [2:0] WIDX_RHI   = 3'd6;
    localparam logic [2:0] WIDX_RXT   = 3'd7;

    function automatic logic op_is_signed(input mac_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_accum(input mac_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/mac_regfile.sv
// Module: mac_regfile
// Decodes the register window. It holds the first operand, the second
// operand and the hidden operation code, and produces the start pulse and
// the result-load strobes. It also drives the combinational read mux.
// Assumes BASE is aligned to 16 bytes and that odd addresses are not decoded.
module mac_regfile
    import mac_pkg::*;
#(
    parameter int                  ADDR_W = 16,
    parameter int                  DATA_W = 16,
    parameter logic [ADDR_W-1:0]   BASE   = 16'h0130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] res_lo,
    input  logic [DATA_W-1:0] res_hi,
    input  logic [DATA_W-1:0] res_xt,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output mac_op_e           op,
    output logic              start,
    output logic              ld_lo,
    output logic              ld_hi
);

    localparam int WIN_LSB = 4;

    logic       in_win;
    logic [2:0] widx;
    logic       wr_opa;

    // Window hit and word index decode.
    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]) && !addr[0];
        widx   = addr[3:1];
    end

    // Write strobes per register.
    always_comb begin
        wr_opa = we && in_win && !widx[2];
        start  = we && in_win && (widx == WIDX_OPB);
        ld_lo  = we && in_win && (widx == WIDX_RLO);
        ld_hi  = we && in_win && (widx == WIDX_RHI);
    end

    // Operand and hidden operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa <= '0;
            opb <= '0;
            op  <= OP_UMUL;
        end else begin
            if (wr_opa) begin
                opa <= wdata;
                op  <= mac_op_e'(widx[1:0]);
            end
            if (start) begin
                opb <= wdata;
            end
        end
    end

    // Read mux; all first-operand aliases return the same value.
    always_comb begin
        rdata = '0;
        if (in_win) begin
            case (widx)
                WIDX_OPB: rdata = opb;
                WIDX_RLO: rdata = res_lo;
                WIDX_RHI: rdata = res_hi;
                WIDX_RXT: rdata = res_xt;
                default:  rdata = opa;
            endcase
        end
    end

    AST_OPA_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_opa |=> (opa == $past(wdata))); // R3

    AST_OPB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(opb)); // R3

endmodule

// File: rtl/mac_mult.sv
// Module: mac_mult
// Pipelined multiplier. Stage 0 captures the operands and the operation
// on a start, and stage 1 forms the product. LATENCY-2 delay stages then
// follow, so the commit strobe appears LATENCY-1 edges after the start and
// the accumulator registers the result on the next edge. Assumes LATENCY >= 3.
module mac_mult
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  mac_op_e             op,
    output logic                commit,
    output mac_op_e             commit_op,
    output logic [2*DATA_W-1:0] commit_prod,
    output logic                busy
);

    localparam int PW   = 2 * DATA_W;
    localparam int XW   = DATA_W + 1;
    localparam int NDLY = LATENCY - 2;

    logic              s0_v;
    mac_op_e           s0_op;
    logic [DATA_W-1:0] s0_a, s0_b;

    logic              s1_v;
    mac_op_e           s1_op;
    logic [PW-1:0]     s1_p;

    logic              dv  [NDLY];
    mac_op_e           dop [NDLY];
    logic [PW-1:0]     dp  [NDLY];

    logic signed [XW-1:0]   xa, xb;
    logic signed [2*XW-1:0] full_p;

    // Stage 0: capture operands and operation at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_v  <= 1'b0;
            s0_op <= OP_UMUL;
            s0_a  <= '0;
            s0_b  <= '0;
        end else begin
            s0_v <= start;
            if (start) begin
                s0_op <= op;
                s0_a  <= opa;
                s0_b  <= opb;
            end
        end
    end

    // Sign- or zero-extend the operands to one extra bit and multiply.
    always_comb begin
        xa     = signed'({op_is_signed(s0_op) & s0_a[DATA_W-1], s0_a});
        xb     = signed'({op_is_signed(s0_op) & s0_b[DATA_W-1], s0_b});
        full_p = xa * xb;
    end

    // Stage 1: register the low PW bits of the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v  <= 1'b0;
            s1_op <= OP_UMUL;
            s1_p  <= '0;
        end else begin
            s1_v  <= s0_v;
            s1_op <= s0_op;
            s1_p  <= full_p[PW-1:0];
        end
    end

    // Delay stages that pad the path to the required latency.
    for (genvar g = 0; g < NDLY; g++) begin : g_dly
        if (g == 0) begin : g_first
            // First delay stage fed from the product stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dv[g]  <= 1'b0;
                    dop[g] <= OP_UMUL;
                    dp[g]  <= '0;
                end else begin
                    dv[g]  <= s1_v;
                    dop[g] <= s1_op;
                    dp[g]  <= s1_p;
                end
            end
        end else begin : g_next
            // Later delay stages fed from the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dv[g]  <= 1'b0;
                    dop[g] <= OP_UMUL;
                    dp[g]  <= '0;
                end else begin
                    dv[g]  <= dv[g-1];
                    dop[g] <= dop[g-1];
                    dp[g]  <= dp[g-1];
                end
            end
        end
    end

    // Outputs: last stage commits; busy while any stage holds work.
    always_comb begin
        commit      = dv[NDLY-1];
        commit_op   = dop[NDLY-1];
        commit_prod = dp[NDLY-1];
        busy        = s0_v | s1_v;
        for (int i = 0; i < NDLY; i++) begin
            busy = busy | dv[i];
        end
    end

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        s0_v |=> s1_v); // R11

endmodule

// File: rtl/mac_accum.sv
// Module: mac_accum
// Holds the two result words and the extension word. On a commit it either
// replaces the result with the product or adds the product into it, and it
// sets the extension word from the carry or the sign. Without a commit,
// software loads of the result words are accepted. A commit wins over a
// load in the same cycle.
module mac_accum
    import mac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  mac_op_e             commit_op,
    input  logic [2*DATA_W-1:0] commit_prod,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   res_lo,
    output logic [DATA_W-1:0]   res_hi,
    output logic [DATA_W-1:0]   res_xt
);

    localparam int PW = 2 * DATA_W;

    logic [PW:0]       sum;
    logic [PW-1:0]     nxt_res;
    logic [DATA_W-1:0] nxt_xt;

    // Next result and extension for a commit.
    always_comb begin
        sum = {1'b0, res_hi, res_lo} + {1'b0, commit_prod};
        if (op_is_accum(commit_op)) begin
            nxt_res = sum[PW-1:0];
            nxt_xt  = op_is_signed(commit_op) ? {DATA_W{sum[PW-1]}}
                                              : {{(DATA_W-1){1'b0}}, sum[PW]};
        end else begin
            nxt_res = commit_prod;
            nxt_xt  = op_is_signed(commit_op) ? {DATA_W{commit_prod[PW-1]}}
                                              : '0;
        end
    end

    // Result and extension registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
            res_xt <= '0;
        end else if (commit) begin
            res_lo <= nxt_res[DATA_W-1:0];
            res_hi <= nxt_res[PW-1:DATA_W];
            res_xt <= nxt_xt;
        end else begin
            if (ld_lo) res_lo <= wdata;
            if (ld_hi) res_hi <= wdata;
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !ld_lo && !ld_hi) |=> $stable({res_hi, res_lo})); // R4

    AST_XT_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(res_xt)); // R10

    AST_UMUL_XT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_op == OP_UMUL) |=> (res_xt == '0)); // R6

    AST_XT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_xt == '0) || (res_xt == {{(DATA_W-1){1'b0}}, 1'b1})
        || (res_xt == {DATA_W{1'b1}})); // R9

endmodule

// File: rtl/mac_periph.sv
// Module: mac_periph (top)
// Multiply-accumulate unit on a register bus. It ties together the register
// decode, the multiplier pipeline and the result accumulator.
// Assumes one bus access per cycle and that reads are combinational.
module mac_periph
    import mac_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 16,
    parameter logic [ADDR_W-1:0] BASE    = 16'h0130,
    parameter int                LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy
);

    localparam int PW = 2 * DATA_W;

    logic [DATA_W-1:0] opa, opb, res_lo, res_hi, res_xt;
    mac_op_e           op, commit_op;
    logic              start, ld_lo, ld_hi, commit;
    logic [PW-1:0]     commit_prod;

    mac_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BASE   (BASE)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .res_lo (res_lo),
        .res_hi (res_hi),
        .res_xt (res_xt),
        .rdata  (bus_rdata),
        .opa    (opa),
        .opb    (opb),
        .op     (op),
        .start  (start),
        .ld_lo  (ld_lo),
        .ld_hi  (ld_hi)
    );

    mac_mult #(
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) i_mult (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .opa         (opa),
        .opb         (bus_wdata),
        .op          (op),
        .commit      (commit),
        .commit_op   (commit_op),
        .commit_prod (commit_prod),
        .busy        (busy)
    );

    mac_accum #(
        .DATA_W (DATA_W)
    ) i_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_op   (commit_op),
        .commit_prod (commit_prod),
        .ld_lo       (ld_lo),
        .ld_hi       (ld_hi),
        .wdata       (bus_wdata),
        .res_lo      (res_lo),
        .res_hi      (res_hi),
        .res_xt      (res_xt)
    );

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R5

    AST_RESULT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!commit && $stable({res_hi, res_lo, res_xt}))); // R4

endmodule

// File: tb/test_mac_periph.sv
`timescale 1ns/10ps
module test_mac_periph;

    localparam logic [15:0] A_UMUL = 16'h0130;
    localparam logic [15:0] A_SMUL = 16'h0132;
    localparam logic [15:0] A_UACC = 16'h0134;
    localparam logic [15:0] A_SACC = 16'h0136;
    localparam logic [15:0] A_OPB  = 16'h0138;
    localparam logic [15:0] A_RLO  = 16'h013A;
    localparam logic [15:0] A_RHI  = 16'h013C;
    localparam logic [15:0] A_RXT  = 16'h013E;

    typedef struct {
        int          due;
        logic [47:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] drv_addr = '0, mon_addr = '0, bus_addr;
    logic        mon_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        busy;

    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    exp_t sb[$];

    // bench model of the block state
    logic [1:0]  m_op = 2'd0;
    logic [15:0] m_a = '0;
    logic [31:0] m_res = '0;
    logic [15:0] m_xt = '0;

    assign bus_addr = mon_sel ? mon_addr : drv_addr;

    mac_periph i_mac_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] model(input logic [1:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic [31:0] acc);
        logic [31:0] p, r;
        logic [32:0] s;
        logic [15:0] e;
        if (op[0]) p = 32'(longint'($signed(a)) * longint'($signed(b)));
        else       p = 32'(longint'(a) * longint'(b));
        if (op[1]) begin
            s = {1'b0, acc} + {1'b0, p};
            r = s[31:0];
            e = op[0] ? {16{s[31]}} : {15'd0, s[32]};
        end else begin
            r = p;
            e = op[0] ? {16{p[31]}} : 16'd0;
        end
        return {e, r};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        drv_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #0.1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        drv_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_a(input logic [15:0] a, input logic [15:0] d);
        wr(a, d);
        m_a  = d;
        m_op = a[2:1];
    endtask

    task automatic preload(input logic [31:0] v);
        wr(A_RLO, v[15:0]);
        wr(A_RHI, v[31:16]);
        m_res = v;
    endtask

    // Start one computation: queue the expected result, then write the operand.
    task automatic go(input logic [15:0] b, input string req);
        exp_t it;
        logic [47:0] v;
        v = model(m_op, m_a, b, m_res);
        @(negedge clk);
        it.due = cyc + 1 + 3;
        it.val = v;
        it.req = req;
        sb.push_back(it);
        m_res = v[31:0];
        m_xt  = v[47:32];
        drv_addr = A_OPB; bus_wdata = b; bus_we = 1'b1;
        @(posedge clk);
        #0.1 bus_we = 1'b0;
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: pop each expected result on its due cycle and compare.
    always @(negedge clk) begin
        #1.5;
        if (sb.size() > 0 && cyc >= sb[0].due) begin
            exp_t it;
            logic [15:0] lo, hi, xt;
            it = sb.pop_front();
            mon_sel = 1'b1;
            mon_addr = A_RLO; #0.2 lo = bus_rdata;
            mon_addr = A_RHI; #0.2 hi = bus_rdata;
            mon_addr = A_RXT; #0.2 xt = bus_rdata;
            mon_sel = 1'b0;
            chk(cyc == it.due, {it.req, " landing cycle R4"}, 48'(cyc), 48'(it.due));
            chk({xt, hi, lo} == it.val, it.req, {xt, hi, lo}, it.val);
        end
    end

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d, lo, hi;
        logic [31:0] old;
        repeat (3) @(posedge clk);
        #0.1 rst_n = 1'b1;

        // R1: reset values
        rd(A_UMUL, d); chk(d == 0, "R1 opa", 48'(d), 0);
        rd(A_OPB, d);  chk(d == 0, "R1 opb", 48'(d), 0);
        rd(A_RLO, d);  chk(d == 0, "R1 res lo", 48'(d), 0);
        rd(A_RHI, d);  chk(d == 0, "R1 res hi", 48'(d), 0);
        rd(A_RXT, d);  chk(d == 0, "R1 ext", 48'(d), 0);
        chk(busy == 0, "R1 busy", 48'(busy), 0);
        // R1: default op is plain unsigned multiply, so preload is replaced
        preload(32'h1234_5678);
        wr(A_UMUL + 16'h0, 16'h0000); m_a = 0; // keep opa 0, mode UMUL
        go(16'h0007, "R1 default op");
        drain();

        // R6 with R4/R5 latency: 0xFFFF*0xFFFF unsigned
        set_a(A_UMUL, 16'hFFFF);
        old = m_res;
        go(16'hFFFF, "R6 umul");
        for (int k = 0; k < 3; k++) begin
            if (k < 2) begin
                rd(A_RLO, lo);
                #0.1 hi = 0;
                chk(lo == old[15:0], "R4 early read", 48'(lo), 48'(old[15:0]));
            end else begin
                @(negedge clk);
            end
            chk(busy == 1, "R5 busy during", 48'(busy), 1);
        end
        drain();
        chk(busy == 0, "R5 busy clears", 48'(busy), 0);

        // R7: signed multiply, negative and positive
        set_a(A_SMUL, 16'hFFFF);
        go(16'h0002, "R7 smul neg");
        drain();
        set_a(A_SMUL, 16'h7FFF);
        go(16'h7FFF, "R7 smul pos");
        drain();

        // R3: first-operand aliases and second operand readback
        set_a(A_SACC, 16'hA5C3);
        rd(A_UMUL, d); chk(d == 16'hA5C3, "R3 alias 0x130", 48'(d), 48'(16'hA5C3));
        rd(A_SMUL, d); chk(d == 16'hA5C3, "R3 alias 0x132", 48'(d), 48'(16'hA5C3));
        rd(A_UACC, d); chk(d == 16'hA5C3, "R3 alias 0x134", 48'(d), 48'(16'hA5C3));
        rd(A_OPB, d);  chk(d == 16'h7FFF, "R3 opb", 48'(d), 48'(16'h7FFF));

        // R8: unsigned accumulate with carry out, then without
        preload(32'hFFFF_FFFF);
        set_a(A_UACC, 16'h0001);
        go(16'h0001, "R8 uacc carry");
        drain();
        set_a(A_UACC, 16'h0002);
        go(16'h0003, "R8 uacc no carry");
        drain();

        // R9: signed accumulate to a negative, then back to positive
        preload(32'h0000_0000);
        set_a(A_SACC, 16'hFFFD);
        go(16'h0005, "R9 sacc neg");
        drain();
        set_a(A_SACC, 16'h0004);
        go(16'h0010, "R9 sacc pos");
        drain();

        // R10: result words load and read back, ext write ignored
        preload(32'hBEEF_CAFE);
        rd(A_RLO, d); chk(d == 16'hCAFE, "R10 lo load", 48'(d), 48'(16'hCAFE));
        rd(A_RHI, d); chk(d == 16'hBEEF, "R10 hi load", 48'(d), 48'(16'hBEEF));
        wr(A_RXT, 16'h1234);
        rd(A_RXT, d); chk(d == m_xt, "R10 ext ignored", 48'(d), 48'(m_xt));

        // R2: last first-operand address decides; switch away from accumulate
        set_a(A_SACC, 16'h0003);
        set_a(A_UMUL, 16'h0003);
        go(16'h0003, "R2 op switch");
        drain();

        // R11: back-to-back accumulating starts
        preload(32'h0000_0010);
        set_a(A_UACC, 16'h0002);
        go(16'h0003, "R11 first");
        go(16'h0004, "R11 second");
        drain();
        rd(A_RLO, d); chk(d == 16'h001E, "R11 final", 48'(d), 48'(16'h001E));

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule